// File: doc/BRIEF.md
# Endpoint Address Translation Cache

This block sits between an endpoint's DMA request source and its request header builder. Every memory read or write that passes through it leaves with a 2-bit address-type tag. The tag is meant for bits 3:2 of header byte 2. Before a request leaves, the block looks up the request's 4 KiB page number in a small fully associative cache of translations. On a hit, the request goes out at once with the cached translated page number and the translated tag.

On a miss, the block turns the request into a translation request and parks the original request. A translation request is a read, tagged 01, that carries the untranslated page address with a zero offset. When the completion returns, the translated page number is written into the cache and the parked request is replayed as translated. If the completion reports failure, nothing is cached and the parked request is replayed untranslated. A one-cycle invalidate input empties the cache and also stops a translation that is still in flight from being cached.

Top module: `ep_xlat_cache`

## Requirements
- R1: After reset, out_valid and cpl_ready are low and the cache holds no valid entry, so the first request misses.
- R2: On a hit, in the same cycle, out_at=2'b10 and out_addr is the cached translated page number followed by req_addr[11:0]. out_wr equals req_wr and req_ready equals out_ready.
- R3: On a miss, the block presents a translation request in the same cycle: out_at=2'b01, out_wr=0, and out_addr set to req_addr with bits 11:0 zeroed. The original request is consumed when out_ready is high.
- R4: While a translation is outstanding, req_ready is low, out_valid is low and cpl_ready is high. cpl_ready is low in every other state.
- R5: One cycle after a successful completion is accepted (cpl_ok=1), the held request is presented with out_at=2'b10, out_addr={cpl_xpage, held offset} and its original out_wr. The page is then cached, so later requests to it hit.
- R6: One cycle after a failed completion is accepted (cpl_ok=0), the held request is presented unchanged with out_at=2'b00. Nothing is cached, so the same page misses again.
- R7: Entries are replaced round-robin across 8 slots. After 9 distinct pages are filled, the first of them misses and the last 8 still hit.
- R8: A high inval clears every entry. A lookup in the same cycle as inval is treated as a miss.
- R9: If inval is high at any point from the acceptance of a translation request up to and including the acceptance of its completion, the result is not cached. The replay still uses it.
- R10: out_at takes only three values: 00 untranslated, 01 translation request, 10 translated. It never takes 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | DMA request present |
| req_ready | output | 1 | DMA request accepted this cycle |
| req_addr | input | 64 | Untranslated byte address |
| req_wr | input | 1 | 1 for write, 0 for read |
| out_valid | output | 1 | Outgoing request present |
| out_ready | input | 1 | Header builder accepts outgoing request |
| out_addr | output | 64 | Outgoing address |
| out_wr | output | 1 | Outgoing write flag |
| out_at | output | 2 | Address-type tag for header byte 2 bits 3:2 |
| cpl_valid | input | 1 | Translation completion present |
| cpl_ready | output | 1 | Completion accepted this cycle |
| cpl_ok | input | 1 | Completion status successful |
| cpl_xpage | input | 52 | Translated page number from the completion |
| inval | input | 1 | Invalidate all entries (single-cycle pulse) |

## Verification
The assertions assume two things about the inputs. First, a completion arrives only while a translation request is outstanding. Second, the DMA source holds its address and write flag steady until the request is accepted. The stimulus keeps both rules. It raises cpl_valid only a few cycles after it has itself seen a tagged-01 request accepted, and it keeps each request fixed until it sees req_ready. Invalidate pulses are placed in three positions: while the block is idle, on the same cycle as a lookup, and during an outstanding translation. Back-pressure on the outgoing side follows a pseudo-random pattern, so that hits, misses and replays all meet stalls.

// File: rtl/ep_xlat_pkg.sv
// Shared encodings for the endpoint translation cache.
// Assumes: the address-type tag is 2 bits wide; 2'b11 is never produced.
package ep_xlat_pkg;
    typedef enum logic [1:0] {
        AT_UNTRANS = 2'b00,
        AT_XREQ    = 2'b01,
        AT_XLATED  = 2'b10
    } at_e;

    typedef enum logic [1:0] {
        ST_LOOKUP = 2'b00,
        ST_WAIT   = 2'b01,
        ST_REPLAY = 2'b10
    } st_e;
endpackage

// File: rtl/ep_xlat_tags.sv
// Fully associative tag store with round-robin fill and invalidate-all.
// Assumes: at most one fill per cycle; no duplicate tags are filled, so at
// most one entry matches. A lookup in an invalidate cycle reports a miss.
module ep_xlat_tags #(
    parameter int ENTRIES = 8,
    parameter int TAG_W   = 52
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAG_W-1:0] lk_tag,
    input  logic             inval,
    input  logic             fill_en,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic [TAG_W-1:0] fill_xpg,
    output logic             lk_hit,
    output logic [TAG_W-1:0] lk_xpg
);
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0] vld_q;
    logic [ENTRIES-1:0] match;
    logic [TAG_W-1:0]   tag_q [ENTRIES];
    logic [TAG_W-1:0]   xpg_q [ENTRIES];
    logic [PTR_W-1:0]   rr_q;

    // Per-entry comparators.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = vld_q[g] && (tag_q[g] == lk_tag);
    end

    // Hit flag; an invalidate in the same cycle hides every entry.
    assign lk_hit = (|match) && !inval;

    // Select the translated page of the single matching entry.
    always_comb begin
        lk_xpg = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            lk_xpg = lk_xpg | (match[i] ? xpg_q[i] : '0);
        end
    end

    // Valid bits and replacement pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            rr_q  <= '0;
        end else if (inval) begin
            vld_q <= '0;
        end else if (fill_en) begin
            vld_q[rr_q] <= 1'b1;
            rr_q        <= (rr_q == PTR_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
        end
    end

    // Tag and payload storage; no reset needed behind the valid bits.
    always_ff @(posedge clk) begin
        if (fill_en && !inval) begin
            tag_q[rr_q] <= fill_tag;
            xpg_q[rr_q] <= fill_xpg;
        end
    end
endmodule

// File: rtl/ep_xlat_ctrl.sv
// Request steering and miss handling for the translation cache.
// Assumes: completions arrive only while a translation is outstanding; the
// requester holds its request stable until req_ready.
module ep_xlat_ctrl
    import ep_xlat_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int OFF_W  = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic                    req_wr,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [ADDR_W-1:0]       out_addr,
    output logic                    out_wr,
    output logic [1:0]              out_at,
    input  logic                    cpl_valid,
    output logic                    cpl_ready,
    input  logic                    cpl_ok,
    input  logic [ADDR_W-OFF_W-1:0] cpl_xpage,
    input  logic                    inval,
    input  logic                    lk_hit,
    input  logic [ADDR_W-OFF_W-1:0] lk_xpg,
    output logic                    fill_en,
    output logic [ADDR_W-OFF_W-1:0] fill_tag,
    output logic [ADDR_W-OFF_W-1:0] fill_xpg
);
    localparam int TAG_W = ADDR_W - OFF_W;

    st_e               st_q;
    logic [ADDR_W-1:0] hold_addr_q;
    logic              hold_wr_q;
    logic              ok_q;
    logic              drop_q;
    logic [TAG_W-1:0]  xpg_q;
    logic              take_miss;
    logic              cpl_fire;

    // Outgoing request mux and handshake outputs per state.
    always_comb begin
        out_valid = 1'b0;
        out_addr  = '0;
        out_wr    = 1'b0;
        out_at    = AT_UNTRANS;
        req_ready = 1'b0;
        cpl_ready = 1'b0;
        unique case (st_q)
            ST_LOOKUP: begin
                out_valid = req_valid;
                req_ready = out_ready;
                if (lk_hit) begin
                    out_at   = AT_XLATED;
                    out_addr = {lk_xpg, req_addr[OFF_W-1:0]};
                    out_wr   = req_wr;
                end else begin
                    out_at   = AT_XREQ;
                    out_addr = {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
                end
            end
            ST_WAIT: cpl_ready = 1'b1;
            ST_REPLAY: begin
                out_valid = 1'b1;
                out_wr    = hold_wr_q;
                if (ok_q) begin
                    out_at   = AT_XLATED;
                    out_addr = {xpg_q, hold_addr_q[OFF_W-1:0]};
                end else begin
                    out_addr = hold_addr_q;
                end
            end
            default: ;
        endcase
    end

    // Event decode for miss capture and completion acceptance.
    assign take_miss = (st_q == ST_LOOKUP) && req_valid && out_ready && !lk_hit;
    assign cpl_fire  = (st_q == ST_WAIT) && cpl_valid;

    // Fill request toward the tag store.
    assign fill_en  = cpl_fire && cpl_ok && !drop_q && !inval;
    assign fill_tag = hold_addr_q[ADDR_W-1:OFF_W];
    assign fill_xpg = cpl_xpage;

    // State register and held-request capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= ST_LOOKUP;
            hold_addr_q <= '0;
            hold_wr_q   <= 1'b0;
            ok_q        <= 1'b0;
            drop_q      <= 1'b0;
            xpg_q       <= '0;
        end else begin
            unique case (st_q)
                ST_LOOKUP: if (take_miss) begin
                    st_q        <= ST_WAIT;
                    hold_addr_q <= req_addr;
                    hold_wr_q   <= req_wr;
                    drop_q      <= inval;
                end
                ST_WAIT: begin
                    if (inval) drop_q <= 1'b1;
                    if (cpl_valid) begin
                        st_q  <= ST_REPLAY;
                        ok_q  <= cpl_ok;
                        xpg_q <= cpl_xpage;
                    end
                end
                ST_REPLAY: if (out_ready) st_q <= ST_LOOKUP;
                default: st_q <= ST_LOOKUP;
            endcase
        end
    end
endmodule

// File: rtl/ep_xlat_cache.sv
// Top of the endpoint address translation cache: tag store plus controller.
// Assumes: one translation outstanding at most; pages of 2**OFF_W bytes.
module ep_xlat_cache #(
    parameter int ADDR_W  = 64,
    parameter int OFF_W   = 12,
    parameter int ENTRIES = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic                    req_wr,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [ADDR_W-1:0]       out_addr,
    output logic                    out_wr,
    output logic [1:0]              out_at,
    input  logic                    cpl_valid,
    output logic                    cpl_ready,
    input  logic                    cpl_ok,
    input  logic [ADDR_W-OFF_W-1:0] cpl_xpage,
    input  logic                    inval
);
    localparam int TAG_W = ADDR_W - OFF_W;

    logic             lk_hit;
    logic [TAG_W-1:0] lk_xpg;
    logic             fill_en;
    logic [TAG_W-1:0] fill_tag;
    logic [TAG_W-1:0] fill_xpg;

    ep_xlat_tags #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_tag   (req_addr[ADDR_W-1:OFF_W]),
        .inval    (inval),
        .fill_en  (fill_en),
        .fill_tag (fill_tag),
        .fill_xpg (fill_xpg),
        .lk_hit   (lk_hit),
        .lk_xpg   (lk_xpg)
    );

    ep_xlat_ctrl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_addr  (req_addr),
        .req_wr    (req_wr),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_addr  (out_addr),
        .out_wr    (out_wr),
        .out_at    (out_at),
        .cpl_valid (cpl_valid),
        .cpl_ready (cpl_ready),
        .cpl_ok    (cpl_ok),
        .cpl_xpage (cpl_xpage),
        .inval     (inval),
        .lk_hit    (lk_hit),
        .lk_xpg    (lk_xpg),
        .fill_en   (fill_en),
        .fill_tag  (fill_tag),
        .fill_xpg  (fill_xpg)
    );
endmodule

// File: rtl/ep_xlat_chk.sv
// Port-level protocol checks for ep_xlat_cache, attached by bind.
// Assumes: completions only while a translation is outstanding.
module ep_xlat_chk #(
    parameter int OFF_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [OFF_W-1:0] req_off,
    input logic             req_wr,
    input logic             out_valid,
    input logic             out_ready,
    input logic [OFF_W-1:0] out_off,
    input logic             out_wr,
    input logic [1:0]       out_at,
    input logic             cpl_valid,
    input logic             cpl_ready,
    input logic             cpl_ok
);
    // R10
    at_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_at != 2'b11);

    // R3
    xreq_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_at == 2'b01) |-> (!out_wr && out_off == '0));

    // R4
    wait_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_ready |-> (!req_ready && !out_valid));

    // R2
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && out_at == 2'b10) |-> (out_off == req_off && out_wr == req_wr));

    // R5
    replay_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && cpl_ready) |=> (out_valid && out_at == ($past(cpl_ok) ? 2'b10 : 2'b00)));

    // R3
    accept_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> (out_valid && out_ready));
endmodule

bind ep_xlat_cache ep_xlat_chk #(.OFF_W(OFF_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_off   (req_addr[OFF_W-1:0]),
    .req_wr    (req_wr),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_off   (out_addr[OFF_W-1:0]),
    .out_wr    (out_wr),
    .out_at    (out_at),
    .cpl_valid (cpl_valid),
    .cpl_ready (cpl_ready),
    .cpl_ok    (cpl_ok)
);

// File: tb/ep_xlat_cache_tb.sv
// Bench for ep_xlat_cache: a behavioural reference model compared each cycle
// plus directed scenario checks.
module ep_xlat_cache_tb;
    localparam int AW = 64;
    localparam int OW = 12;
    localparam int TW = AW - OW;
    localparam int N  = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n;
    logic          req_valid, req_ready, req_wr;
    logic [AW-1:0] req_addr;
    logic          out_valid, out_ready, out_wr;
    logic [AW-1:0] out_addr;
    logic [1:0]    out_at;
    logic          cpl_valid, cpl_ready, cpl_ok;
    logic [TW-1:0] cpl_xpage;
    logic          inval;

    ep_xlat_cache u_dut (.*);

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    // stimulus state
    logic [AW-1:0] cur_addr;
    logic          cur_wr;
    logic          cur_on;
    logic          fail_next, inval_req, stall_mode;
    logic [15:0]   lfsr;
    logic          cpl_pend, cpl_fail;
    int            cpl_cnt;
    logic [TW-1:0] cpl_page;
    logic [1:0]    last_at;

    function automatic logic [TW-1:0] xmap(input logic [TW-1:0] p);
        return p ^ 52'h9_1234_5678_9ABC;
    endfunction

    task automatic chk(input string rq, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // One clock of stimulus, driven at the falling edge.
    task automatic cycle();
        @(negedge clk);
        out_ready = stall_mode ? lfsr[0] : 1'b1;
        lfsr      = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        req_valid = cur_on;
        req_addr  = cur_addr;
        req_wr    = cur_wr;
        inval     = inval_req;
        inval_req = 1'b0;
        cpl_valid = 1'b0;
        if (cpl_pend) begin
            if (cpl_cnt == 0) begin
                cpl_valid = 1'b1;
                cpl_xpage = xmap(cpl_page);
                cpl_ok    = !cpl_fail;
            end else begin
                cpl_cnt--;
            end
        end
        #1;
        if (cpl_valid && cpl_ready) cpl_pend = 1'b0;
        if (out_valid && out_ready && out_at == 2'b01) begin
            cpl_pend = 1'b1;
            cpl_cnt  = 2;
            cpl_page = out_addr[AW-1:OW];
            cpl_fail = fail_next;
        end
        if (req_valid && req_ready) begin
            cur_on  = 1'b0;
            last_at = out_at;
        end
    endtask

    task automatic drain();
        repeat (14) cycle();
    endtask

    // Issue one request; check the tag seen at its acceptance unless rq is empty.
    task automatic issue(input logic [AW-1:0] a, input logic w, input logic [1:0] exp_at, input string rq);
        cur_addr = a;
        cur_wr   = w;
        cur_on   = 1'b1;
        while (cur_on) cycle();
        if (rq != "") chk(rq, AW'(last_at), AW'(exp_at));
    endtask

    // ---------------- reference model ----------------
    int            ms;
    logic          mv [N];
    logic [TW-1:0] mt [N];
    logic [TW-1:0] mx [N];
    int            mrr;
    logic [AW-1:0] mh_addr;
    logic          mh_wr, mok, mdrop;
    logic [TW-1:0] mxp;

    always @(negedge clk) begin
        #2;
        if (!rst_n) begin
            ms = 0; mrr = 0; mdrop = 1'b0; mok = 1'b0;
            for (int i = 0; i < N; i++) mv[i] = 1'b0;
        end else begin
            int hit_i;
            string tag;
            logic          e_v, e_wr, e_rr, e_cr;
            logic [1:0]    e_at;
            logic [AW-1:0] e_a;
            hit_i = -1;
            e_v = 0; e_wr = 0; e_at = 0; e_a = '0; e_rr = 0; e_cr = 0;
            if (ms == 0) begin
                for (int i = 0; i < N; i++)
                    if (mv[i] && mt[i] == req_addr[AW-1:OW] && !inval) hit_i = i;
                e_v  = req_valid;
                e_rr = out_ready;
                if (hit_i >= 0) begin
                    tag = "R2"; e_at = 2'b10; e_a = {mx[hit_i], req_addr[OW-1:0]}; e_wr = req_wr;
                end else begin
                    tag = "R3"; e_at = 2'b01; e_a = {req_addr[AW-1:OW], {OW{1'b0}}}; e_wr = 1'b0;
                end
            end else if (ms == 1) begin
                tag = "R4"; e_cr = 1'b1;
            end else begin
                e_v = 1'b1; e_wr = mh_wr;
                if (mok) begin tag = "R5"; e_at = 2'b10; e_a = {mxp, mh_addr[OW-1:0]}; end
                else     begin tag = "R6"; e_at = 2'b00; e_a = mh_addr; end
            end
            chk(tag, AW'(out_valid), AW'(e_v));
            chk(tag, AW'(req_ready), AW'(e_rr));
            chk(tag, AW'(cpl_ready), AW'(e_cr));
            if (e_v) begin
                chk(tag, AW'(out_at), AW'(e_at));
                chk(tag, out_addr, e_a);
                chk(tag, AW'(out_wr), AW'(e_wr));
            end
            if (out_valid) chk("R10", AW'(out_at != 2'b11), 1);
            // advance model as the coming rising edge will
            if (inval) for (int i = 0; i < N; i++) mv[i] = 1'b0;
            if (ms == 0) begin
                if (req_valid && out_ready && hit_i < 0) begin
                    ms = 1; mh_addr = req_addr; mh_wr = req_wr; mdrop = inval;
                end
            end else if (ms == 1) begin
                if (inval) mdrop = 1'b1;
                if (cpl_valid) begin
                    if (cpl_ok && !mdrop && !inval) begin
                        mv[mrr] = 1'b1; mt[mrr] = mh_addr[AW-1:OW]; mx[mrr] = cpl_xpage;
                        mrr = (mrr + 1) % N;
                    end
                    mok = cpl_ok; mxp = cpl_xpage; ms = 2;
                end
            end else if (out_ready) begin
                ms = 0;
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] pa, pb, pc, base;
        rst_n = 1'b0; req_valid = 0; req_addr = '0; req_wr = 0; out_ready = 1;
        cpl_valid = 0; cpl_ok = 0; cpl_xpage = '0; inval = 0;
        cur_on = 0; cur_addr = '0; cur_wr = 0; fail_next = 0; inval_req = 0;
        stall_mode = 0; lfsr = 16'hACE1; cpl_pend = 0; cpl_fail = 0; cpl_cnt = 0;
        cpl_page = '0; last_at = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        cycle();
        // R1: idle outputs after reset
        chk("R1", AW'(out_valid), 0);
        chk("R1", AW'(cpl_ready), 0);

        pa = 64'h0000_1234_5678_9000;
        issue(pa | 64'h234, 1'b0, 2'b01, "R1");
        drain();
        issue(pa | 64'hABC, 1'b1, 2'b10, "R5");
        issue(pa | 64'h001, 1'b0, 2'b10, "R2");

        // R6: failed translation is not cached
        pb = 64'h0000_0BAD_0000_7000;
        fail_next = 1'b1;
        issue(pb | 64'h044, 1'b1, 2'b01, "R6");
        fail_next = 1'b0;
        drain();
        issue(pb | 64'h048, 1'b0, 2'b01, "R6");
        drain();

        // R7: round-robin eviction over nine pages
        inval_req = 1'b1; cycle();
        base = 64'h0000_0777_0000_0000;
        for (int i = 0; i < 9; i++) begin
            issue(base + (64'(i) << OW) + 64'h10, i[0], 2'b01, "R7");
            drain();
        end
        issue(base + (64'(8) << OW), 1'b0, 2'b10, "R7");
        issue(base + (64'(1) << OW), 1'b1, 2'b10, "R7");
        issue(base + (64'(0) << OW), 1'b0, 2'b01, "R7");
        drain();

        // R8: invalidate clears; same-cycle lookup misses
        inval_req = 1'b1; cycle();
        issue(base + (64'(8) << OW), 1'b0, 2'b01, "R8");
        drain();
        issue(base + (64'(8) << OW), 1'b0, 2'b10, "R8");
        inval_req = 1'b1;
        issue(base + (64'(8) << OW), 1'b1, 2'b01, "R8");
        drain();
        issue(base + (64'(8) << OW), 1'b0, 2'b01, "R9");
        drain();

        // R9: invalidate while a translation is outstanding
        pc = 64'h0000_0CCC_0000_3000;
        issue(pc | 64'h7FF, 1'b1, 2'b01, "R9");
        inval_req = 1'b1; cycle();
        drain();
        issue(pc | 64'h7F0, 1'b0, 2'b01, "R9");
        drain();
        issue(pc | 64'h7F8, 1'b0, 2'b10, "R9");

        // mixed traffic with back-pressure, checked by the model
        stall_mode = 1'b1;
        for (int i = 0; i < 40; i++) begin
            fail_next = (i % 7 == 3);
            issue(64'h0000_0055_0000_0000 + (64'(i % 5) << OW) + 64'(i * 3), i[1], 2'b00, "");
            if (i % 11 == 5) inval_req = 1'b1;
        end
        fail_next = 1'b0;
        drain();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule